// File: doc/BRIEF.md
# Daisy-Chain Converter Serial Port Node

This block models the digital serial side of one 14-bit sampling converter that can be strung into a chain with others sharing one conversion-start line and one serial clock. Each node's serial input is fed by the serial output of the node further from the host. The node farthest from the host has its serial input tied to the conversion-start line. All inputs are sampled on a system clock, and a down-counter stands in for the conversion time.

A rising edge on the conversion-start line while the serial clock is high begins a conversion in chain mode with the busy indication turned on. When a node's own conversion time has passed, it latches the parallel result into a shift register. It then holds its serial output low until its serial input goes high. A high level therefore travels toward the host only after every node has finished, and the host sees one completion edge. The first falling serial-clock edge after that consumes the indication. Each later falling edge moves the whole chain on by one bit, like one long shift register: own result MSB first, then the bits arriving from upstream. A chain of N nodes needs 14·N+1 falling edges. Dropping the conversion-start line returns a node to idle.

Top module: `chain_adc_port`

## Requirements
- R1: While reset is asserted and right after it, the serial output is low.
- R2: Within two system clocks of the conversion-start line being sampled low, the serial output is low, and it stays low while that line stays low.
- R3: A conversion starts only on a rising edge of the conversion-start line seen while the serial clock is high. A rising edge with the serial clock low starts nothing, and the serial output stays low even though the far-end serial input is high.
- R4: The serial output goes high to signal completion only after the node's own conversion has finished and its serial input is high. A node that has finished stays low while its serial input is low.
- R5: A conversion lasts CONV_CYCLES system clocks from its start before the result is latched. No node signals completion earlier.
- R6: The first falling serial-clock edge after the completion signal consumes it, and the serial output then shows bit 13 (the MSB) of the node's own result.
- R7: Each later falling edge shifts by one bit. The node's own 14 result bits come out MSB first, followed by the serial-input bits in arrival order, so the host reads the indication plus 14·N data bits with 14·N+1 falling edges. Between falling edges the output holds.
- R8: Falling serial-clock edges during a conversion have no effect on the bits later read back.
- R9: While the conversion-start line stays high, a conversion or readback in progress is never aborted, however long the pause between serial-clock edges.
- R10: The parallel result is captured at the moment the conversion time expires. Changes before that moment are taken; changes after it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnv_i | input | 1 | Conversion-start line, held high through conversion and readback |
| sck_i | input | 1 | Serial clock; falling edges shift the chain |
| sdi_i | input | 1 | Serial input from the upstream node (tied to cnv_i at the far end) |
| result_i | input | DATA_W | Parallel conversion result |
| sdo_o | output | 1 | Registered serial output toward the host |

## Verification
The bound checker watches on every cycle that the output drops when the start line is low, and that no conversion begins while the sampled serial clock is low. It also confirms that completion is never signalled with the serial input low, that a conversion is not left before its cycle count is reached, that the output moves during readback only on falling serial-clock edges, and that nothing aborts while the start line is high. Only the bench scenarios can show that the completion edge ripples correctly through three nodes with different conversion times. The same holds for the exact bit order across the whole chain, the capture moment of the result, and the harmlessness of serial-clock activity during conversion.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_READY = 3'd3,
    ST_SHIFT = 3'd4
  } state_t;
endpackage

// File: rtl/chain_adc_sync.sv
// Samples asynchronous-looking pins on the system clock. The low NEDGE
// bits also keep their previous sample so edges can be detected.
module chain_adc_sync #(
  parameter int NBITS = 3,
  parameter int NEDGE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] raw_i,
  output logic [NBITS-1:0] lvl_o,
  output logic [NEDGE-1:0] prv_o
);
  logic [NBITS-1:0] lvl_q;
  logic [NEDGE-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= raw_i;
  end

  genvar g;
  generate
    for (g = 0; g < NEDGE; g++) begin : g_prev
      always_ff @(posedge clk) begin
        if (rst) prv_q[g] <= 1'b0;
        else     prv_q[g] <= lvl_q[g];
      end
    end
  endgenerate

  assign lvl_o = lvl_q;
  assign prv_o = prv_q;
endmodule

// File: rtl/chain_adc_timer.sv
// Counts the conversion time; expire_o is high for the last cycle.
module chain_adc_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic clear_i,
  output logic expire_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/chain_adc_shreg.sv
// Parallel-load, serial-in shift register, moving toward the MSB.
module chain_adc_shreg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_i)  q <= data_i;
    else if (shift_i) q <= {q[W-2:0], ser_i};
  end

  assign q_o = q;
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port #(
  parameter int DATA_W      = 14,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdo_o
);
  import chain_adc_pkg::*;

  localparam int MSB = DATA_W - 1;

  logic [2:0] pin_lvl;
  logic [1:0] pin_prv;
  logic       cnv_q, sck_q, sdi_q;
  logic       cnv_rise, sck_fall;
  logic       start, expire, load, shift;
  logic [DATA_W-1:0] sreg_q;
  state_t     state_q;
  logic       sdo_q;

  chain_adc_sync #(.NBITS(3), .NEDGE(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_i ({sdi_i, sck_i, cnv_i}),
    .lvl_o (pin_lvl),
    .prv_o (pin_prv)
  );

  assign cnv_q    = pin_lvl[0];
  assign sck_q    = pin_lvl[1];
  assign sdi_q    = pin_lvl[2];
  assign cnv_rise = cnv_q & ~pin_prv[0];
  assign sck_fall = ~sck_q & pin_prv[1];

  assign start = (state_q == ST_IDLE) && cnv_rise && sck_q;
  assign load  = (state_q == ST_CONV) && cnv_q && expire;
  assign shift = (state_q == ST_SHIFT) && cnv_q && sck_fall;

  chain_adc_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .clear_i  (~cnv_q),
    .expire_o (expire)
  );

  chain_adc_shreg #(.W(DATA_W)) u_shreg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .data_i  (result_i),
    .shift_i (shift),
    .ser_i   (sdi_q),
    .q_o     (sreg_q)
  );

  always_ff @(posedge clk) begin
    if (rst || !cnv_q) begin
      state_q <= ST_IDLE;
      sdo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start) state_q <= ST_CONV;
        ST_CONV:  if (expire) state_q <= ST_WAIT;
        ST_WAIT:  if (sdi_q) begin
                    state_q <= ST_READY;
                    sdo_q   <= 1'b1;
                  end
        ST_READY: if (sck_fall) begin
                    state_q <= ST_SHIFT;
                    sdo_q   <= sreg_q[MSB];
                  end
        ST_SHIFT: if (sck_fall) sdo_q <= sreg_q[MSB-1];
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk #(
  parameter int CONV_CYCLES = 40
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cnv_i,
  input logic                   sdo_o,
  input logic                   cnv_q,
  input logic                   sck_q,
  input logic                   sdi_q,
  input logic                   sck_fall,
  input chain_adc_pkg::state_t  state
);
  import chain_adc_pkg::*;

  int conv_cnt;
  always_ff @(posedge clk) begin
    if (rst || state != ST_CONV) conv_cnt <= 0;
    else                         conv_cnt <= conv_cnt + 1;
  end

  p_low_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !cnv_i |=> ##1 !sdo_o);

  p_start_needs_sck_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !sck_q) |=> state != ST_CONV);

  p_done_needs_sdi_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !sdi_q) |=> (state != ST_READY && !sdo_o));

  p_conv_time_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && cnv_q && conv_cnt < CONV_CYCLES - 1) |=> state == ST_CONV);

  p_consume_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READY && cnv_q && sck_fall) |=> state == ST_SHIFT);

  p_shift_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && cnv_q && !sck_fall) |=> $stable(sdo_o));

  p_no_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && cnv_q) |=> state != ST_IDLE);
endmodule

bind chain_adc_port chain_adc_port_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnv_i    (cnv_i),
  .sdo_o    (sdo_o),
  .cnv_q    (cnv_q),
  .sck_q    (sck_q),
  .sdi_q    (sdi_q),
  .sck_fall (sck_fall),
  .state    (state_q)
);

// File: tb/chain_adc_port_bench.sv
module chain_adc_port_bench;
  localparam int CLK_P = 10;
  localparam int W     = 14;
  localparam int NODES = 3;
  localparam int HALF  = 4;
  localparam int T_FAR = 30;
  localparam int T_MID = 50;
  localparam int T_TOP = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv = 1'b0;
  logic sck = 1'b0;
  logic [W-1:0] res_far = '0, res_mid = '0, res_top = '0;
  logic sdo_far, sdo_mid, sdo_top;

  always #(CLK_P/2) clk = ~clk;

  chain_adc_port #(.DATA_W(W), .CONV_CYCLES(T_FAR)) u_far (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(cnv),
    .result_i(res_far), .sdo_o(sdo_far));
  chain_adc_port #(.DATA_W(W), .CONV_CYCLES(T_MID)) u_mid (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdo_far),
    .result_i(res_mid), .sdo_o(sdo_mid));
  chain_adc_port #(.DATA_W(W), .CONV_CYCLES(T_TOP)) u_chain_adc_port (
    .clk(clk), .rst(rst), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdo_mid),
    .result_i(res_top), .sdo_o(sdo_top));

  int    n_chk = 0;
  int    n_fail = 0;
  bit    exp_q[$];
  logic  rd_stb = 1'b0;
  string rd_tag = "R7";
  bit    done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected bit per host read strobe.
  always @(negedge clk) begin
    if (rd_stb) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 scoreboard empty", sdo_top, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(sdo_top == e, rd_tag, sdo_top, e);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  // Host samples SDO just before each falling SCK edge.
  task automatic read_bit();
    @(posedge clk); rd_stb <= 1'b1;
    @(posedge clk); rd_stb <= 1'b0;
    @(negedge clk); sck = 1'b0;
    wait_cyc(HALF);
    sck = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic run_round(logic [W-1:0] a, logic [W-1:0] b,
                           logic [W-1:0] c_early, logic [W-1:0] c_final,
                           bit toggle, int pause_at);
    int cyc;
    res_far = a; res_mid = b; res_top = c_early;
    sck = 1'b1;
    wait_cyc(3);
    cnv = 1'b1;
    cyc = 0;
    // R8: optional SCK activity during conversion, ending high
    for (int i = 0; i < 20; i++) begin
      wait_cyc(1); cyc++;
      if (toggle && i >= 4 && i < 16) sck = ~sck;
    end
    sck = 1'b1;
    res_top = c_final;            // R10: before the top node expires
    while (cyc < 46) begin wait_cyc(1); cyc++; end
    chk(sdo_top == 1'b0, "R4 waits for upstream", sdo_top, 0);
    while (sdo_top == 1'b0 && cyc < 120) begin wait_cyc(1); cyc++; end
    chk(sdo_top == 1'b1, "R4 completion signalled", sdo_top, 1);
    chk(cyc >= T_MID, "R5 no early completion", cyc, T_MID);
    res_top = ~c_final;           // R10: after capture, must be ignored
    wait_cyc(5);
    exp_q.push_back(1'b1);
    push_word(c_final);
    push_word(b);
    push_word(a);
    for (int k = 0; k < NODES * W + 1; k++) begin
      if (k == 0) rd_tag = "R6 indicator";
      else if (k <= W) rd_tag = "R7 R8 R10 own bits";
      else rd_tag = "R7 upstream bits";
      if (k == pause_at) wait_cyc(200);   // R9: long pause, CNV high
      read_bit();
    end
    chk(exp_q.size() == 0, "R7 all bits read", exp_q.size(), 0);
    cnv = 1'b0;
    wait_cyc(3);
    chk(sdo_top == 1'b0, "R2 low after CNV drop", sdo_top, 0);
    wait_cyc(10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    wait_cyc(4);
    chk(sdo_top == 1'b0, "R1 during reset", sdo_top, 0);
    rst = 1'b0;
    wait_cyc(2);
    chk(sdo_top == 1'b0, "R1 after reset", sdo_top, 0);
    chk(sdo_mid == 1'b0 && sdo_far == 1'b0, "R2 idle chain low",
        {sdo_mid, sdo_far}, 0);

    // R3: rising CNV with SCK low starts nothing
    sck = 1'b0;
    wait_cyc(2);
    cnv = 1'b1;
    wait_cyc(60);
    chk(sdo_top == 1'b0, "R3 no start, SCK low", sdo_top, 0);
    wait_cyc(60);
    chk(sdo_top == 1'b0, "R3 still idle", sdo_top, 0);
    chk(sdo_far == 1'b0, "R3 far node idle with SDI high", sdo_far, 0);
    cnv = 1'b0;
    wait_cyc(5);

    run_round(14'h1234, 14'h2ABC, 14'h0F0F, 14'h3A5C, 1'b0, 20);
    run_round(14'h3FFF, 14'h0000, 14'h0001, 14'h2AAA, 1'b1, 0);
    run_round(14'h0001, 14'h2000, 14'h3FFF, 14'h1555, 1'b1, 35);

    finish_run();
  end
endmodule